// File: doc/BRIEF.md
# Superpage-Aware Address Translation Cache

This block is a small, fully associative translation cache for a paged virtual-memory unit. Each slot holds one translation: an address-space tag, a global flag, the virtual page base, the physical page base, the raw page-table entry, and the physical address of that entry, which is kept so that a later dirty-bit update knows where to write. At fill time the page level (4 KiB, 2 MiB or 1 GiB) sets a per-slot pair of masks. One mask selects the page-offset bits and the other keeps the page-number bits, so a single parallel lookup covers slots of mixed page sizes.

The lookup port is purely combinational against the stored state. It returns hit, the translated physical address (page base OR the request offset bits), the stored entry and its address. Fills and fence-style invalidations are registered. A fill goes to the lowest-numbered empty slot, or else replaces the slot that was filled longest ago. An invalidation is filtered by tag, by address, by both or by neither, and global slots get special handling.

Top module: `tlb_xlat_cache`

## Requirements
- R1: After synchronous reset every slot is empty and a lookup reports no hit.
- R2: A fill with level L (0..2) sets the page shift to 12 + 9*L. The stored virtual base keeps only the bits at and above the shift. The stored physical base has its low shift bits cleared.
- R3: A lookup hits a slot when the slot is valid, is global or has a tag equal to the request tag, and its virtual base equals the request address with the bits below the shift cleared. On a hit the physical address is the stored base OR the request's bits below the shift, and the stored entry and entry address are returned.
- R4: When no slot hits, lk_hit is 0 and lk_pa, lk_pte and lk_pte_addr are all 0.
- R5: When several slots hit, the outputs come from the lowest-numbered one.
- R6: A fill writes the lowest-numbered empty slot when one exists.
- R7: When all slots are full, a fill replaces the slot with the oldest fill time, taken from a free-running cycle counter.
- R8: An invalidation with neither filter enabled empties every slot.
- R9: An invalidation filtered by address only empties every slot whose page contains that address, global slots included.
- R10: An invalidation filtered by tag only empties non-global slots with that tag. Global slots are kept.
- R11: An invalidation filtered by tag and address empties only non-global slots that match both.
- R12: An invalidation takes effect at the next clock edge. A lookup in the same cycle sees the state from before the invalidation.
- R13: When a fill and an invalidation happen in the same cycle, the slot chosen from the state before the invalidation receives the new entry and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Write one translation this cycle |
| fill_asid | input | ASID_W | Address-space tag of the new entry |
| fill_global | input | 1 | New entry matches every tag |
| fill_level | input | LVL_W | Page level, 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_va | input | VA_W | Virtual address inside the page |
| fill_pa | input | PA_W | Physical address inside the page |
| fill_pte | input | PTE_W | Raw page-table entry |
| fill_pte_addr | input | PA_W | Physical address of the page-table entry |
| lk_asid | input | ASID_W | Lookup tag |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | A slot matched |
| lk_pa | output | PA_W | Translated physical address |
| lk_pte | output | PTE_W | Stored page-table entry of the matching slot |
| lk_pte_addr | output | PA_W | Stored entry address of the matching slot |
| fl_en | input | 1 | Invalidate this cycle |
| fl_by_asid | input | 1 | Filter the invalidation by tag |
| fl_asid | input | ASID_W | Tag filter value |
| fl_by_va | input | 1 | Filter the invalidation by address |
| fl_va | input | VA_W | Address filter value |

## Verification
The lookup outputs are combinational from the slot registers, so the expected result is due in the same cycle as the lookup inputs. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. Fills and invalidations change the slot state at the next rising edge, so their effect is due on the first lookup of the following cycle. The bench's reference array applies each update only after that cycle's comparison, which also covers a lookup made in the same cycle as an invalidation (R12).

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned TLB_ENTRIES   = 8;
    localparam int unsigned ASID_BITS     = 9;
    localparam int unsigned VA_BITS       = 39;
    localparam int unsigned PA_BITS       = 56;
    localparam int unsigned PTE_BITS      = 64;
    localparam int unsigned PAGE_OFS_BITS = 12;
    localparam int unsigned LVL_IDX_BITS  = 9;
    localparam int unsigned LEVELS        = 3;
    localparam int unsigned AGE_BITS      = 32;

    typedef enum logic [1:0] {
        FL_ALL  = 2'd0,
        FL_ADDR = 2'd1,
        FL_TAG  = 2'd2,
        FL_BOTH = 2'd3
    } flush_kind_e;

    function automatic flush_kind_e decode_flush(input logic by_tag, input logic by_addr);
        case ({by_tag, by_addr})
            2'b00:   return FL_ALL;
            2'b01:   return FL_ADDR;
            2'b10:   return FL_TAG;
            default: return FL_BOTH;
        endcase
    endfunction

    // Page shift for a level; out-of-range levels clamp to the largest page.
    function automatic int unsigned page_shift(input int unsigned lvl,
                                               input int unsigned ofs_w,
                                               input int unsigned lvl_w,
                                               input int unsigned max_lvl);
        int unsigned l;
        l = (lvl > max_lvl) ? max_lvl : lvl;
        return ofs_w + l * lvl_w;
    endfunction

endpackage

// File: rtl/tlb_slot_match.sv
module tlb_slot_match
    import tlb_pkg::*;
#(
    parameter int unsigned ASID_W = ASID_BITS,
    parameter int unsigned VA_W   = VA_BITS
) (
    input  logic              e_valid,
    input  logic              e_global,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [VA_W-1:0]   e_vbase,
    input  logic [VA_W-1:0]   e_keep,
    input  logic [ASID_W-1:0] q_asid,
    input  logic [VA_W-1:0]   q_va,
    input  flush_kind_e       f_kind,
    input  logic [ASID_W-1:0] f_asid,
    input  logic [VA_W-1:0]   f_va,
    output logic              q_hit,
    output logic              f_hit
);

    logic tag_ok, page_ok, f_tag_eq, f_page_eq;

    always_comb begin
        tag_ok    = e_global || (e_asid == q_asid);
        page_ok   = (e_vbase == (q_va & e_keep));
        q_hit     = e_valid && tag_ok && page_ok;
        f_tag_eq  = (e_asid == f_asid) && !e_global;
        f_page_eq = (e_vbase == (f_va & e_keep));
        case (f_kind)
            FL_ALL:  f_hit = 1'b1;
            FL_ADDR: f_hit = f_page_eq;
            FL_TAG:  f_hit = f_tag_eq;
            default: f_hit = f_tag_eq && f_page_eq;
        endcase
    end

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned AGE_W = 32,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic [IDX_W-1:0]        idx
);

    logic             found;
    logic [AGE_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = age[0];
        for (int i = 0; i < N; i++) begin
            if (!found && !valid[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = 1; i < N; i++) begin
                if (age[i] < best) begin
                    best = age[i];
                    idx  = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/tlb_xlat_cache.sv
module tlb_xlat_cache
    import tlb_pkg::*;
#(
    parameter int unsigned N        = TLB_ENTRIES,
    parameter int unsigned ASID_W   = ASID_BITS,
    parameter int unsigned VA_W     = VA_BITS,
    parameter int unsigned PA_W     = PA_BITS,
    parameter int unsigned PTE_W    = PTE_BITS,
    parameter int unsigned OFS_W    = PAGE_OFS_BITS,
    parameter int unsigned LVLIDX_W = LVL_IDX_BITS,
    parameter int unsigned NLVL     = LEVELS,
    parameter int unsigned AGE_W    = AGE_BITS,
    parameter int unsigned LVL_W    = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [PTE_W-1:0]  fill_pte,
    input  logic [PA_W-1:0]   fill_pte_addr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [PTE_W-1:0]  lk_pte,
    output logic [PA_W-1:0]   lk_pte_addr,
    input  logic              fl_en,
    input  logic              fl_by_asid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_by_va,
    input  logic [VA_W-1:0]   fl_va
);

    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   vbase;   // page-number bits only
        logic [VA_W-1:0]   keep;    // match mask
        logic [VA_W-1:0]   ofs;     // selection mask
        logic [PA_W-1:0]   pbase;
        logic [PTE_W-1:0]  pte;
        logic [PA_W-1:0]   pte_pa;
        logic [AGE_W-1:0]  age;
    } slot_t;

    slot_t                   slot_q [N];
    logic [N-1:0]            valid_q;
    logic [AGE_W-1:0]        cyc_q;
    logic [N-1:0]            q_hit_v, f_hit_v;
    logic [N-1:0][AGE_W-1:0] age_v;
    logic [IDX_W-1:0]        vict_idx, sel_idx;
    flush_kind_e             fl_kind;
    int unsigned             fill_sh;
    logic [VA_W-1:0]         fill_ofs;
    logic [PA_W-1:0]         fill_pofs;
    slot_t                   fill_slot;

    // ---------------- fill preparation ----------------
    always_comb begin
        fill_sh         = page_shift(32'(fill_level), OFS_W, LVLIDX_W, NLVL - 1);
        fill_ofs        = (VA_W'(1) << fill_sh) - VA_W'(1);
        fill_pofs       = (PA_W'(1) << fill_sh) - PA_W'(1);
        fill_slot.asid  = fill_asid;
        fill_slot.glob  = fill_global;
        fill_slot.keep  = ~fill_ofs;
        fill_slot.ofs   = fill_ofs;
        fill_slot.vbase = fill_va & ~fill_ofs;
        fill_slot.pbase = fill_pa & ~fill_pofs;
        fill_slot.pte   = fill_pte;
        fill_slot.pte_pa = fill_pte_addr;
        fill_slot.age   = cyc_q;
        fl_kind         = decode_flush(fl_by_asid, fl_by_va);
    end

    // ---------------- per-slot compare ----------------
    for (genvar g = 0; g < N; g++) begin : g_slot
        tlb_slot_match #(.ASID_W(ASID_W), .VA_W(VA_W)) u_match (
            .e_valid (valid_q[g]),
            .e_global(slot_q[g].glob),
            .e_asid  (slot_q[g].asid),
            .e_vbase (slot_q[g].vbase),
            .e_keep  (slot_q[g].keep),
            .q_asid  (lk_asid),
            .q_va    (lk_va),
            .f_kind  (fl_kind),
            .f_asid  (fl_asid),
            .f_va    (fl_va),
            .q_hit   (q_hit_v[g]),
            .f_hit   (f_hit_v[g])
        );
        assign age_v[g] = slot_q[g].age;

        // R10: a tag-only invalidation never removes a global slot
        assert_tag_flush_spares_global_R10: assert property (@(posedge clk) disable iff (rst)
            (fl_en && fl_by_asid && !fl_by_va && valid_q[g] && slot_q[g].glob
             && !(fill_en && vict_idx == IDX_W'(g)))
            |=> valid_q[g]);
    end

    tlb_prio_sel #(.N(N), .IDX_W(IDX_W)) u_prio (
        .req(q_hit_v),
        .any(lk_hit),
        .idx(sel_idx)
    );

    tlb_victim_pick #(.N(N), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .valid(valid_q),
        .age  (age_v),
        .idx  (vict_idx)
    );

    // ---------------- lookup result ----------------
    always_comb begin
        lk_pa       = '0;
        lk_pte      = '0;
        lk_pte_addr = '0;
        if (lk_hit) begin
            lk_pa       = slot_q[sel_idx].pbase | PA_W'(lk_va & slot_q[sel_idx].ofs);
            lk_pte      = slot_q[sel_idx].pte;
            lk_pte_addr = slot_q[sel_idx].pte_pa;
        end
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            cyc_q   <= '0;
        end else begin
            cyc_q <= cyc_q + AGE_W'(1);
            for (int i = 0; i < N; i++) begin
                if (fl_en && f_hit_v[i]) valid_q[i] <= 1'b0;
            end
            if (fill_en) valid_q[vict_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !rst) slot_q[vict_idx] <= fill_slot;
    end

    // ---------------- assertions ----------------
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0 && !lk_hit));

    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == '0 && lk_pte == '0 && lk_pte_addr == '0));

    assert_fill_grows_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !fl_en && !(&valid_q))
        |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

    assert_full_stays_full_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !fl_en && (&valid_q)) |=> (&valid_q));

    assert_flush_all_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !fl_by_asid && !fl_by_va && !fill_en) |=> (valid_q == '0));

    assert_fill_survives_flush_R13: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(vict_idx)]);

endmodule

// File: tb/tlb_xlat_cache_bench.sv
module tlb_xlat_cache_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_en = 0, fill_global = 0;
    logic [8:0]  fill_asid = 0;
    logic [1:0]  fill_level = 0;
    logic [38:0] fill_va = 0;
    logic [55:0] fill_pa = 0, fill_pte_addr = 0;
    logic [63:0] fill_pte = 0;
    logic [8:0]  lk_asid = 0;
    logic [38:0] lk_va = 0;
    logic        lk_hit;
    logic [55:0] lk_pa, lk_pte_addr;
    logic [63:0] lk_pte;
    logic        fl_en = 0, fl_by_asid = 0, fl_by_va = 0;
    logic [8:0]  fl_asid = 0;
    logic [38:0] fl_va = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_xlat_cache u_tlb_xlat_cache (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_global(fill_global),
        .fill_level(fill_level), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_pte(fill_pte), .fill_pte_addr(fill_pte_addr),
        .lk_asid(lk_asid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_pte(lk_pte), .lk_pte_addr(lk_pte_addr),
        .fl_en(fl_en), .fl_by_asid(fl_by_asid), .fl_asid(fl_asid),
        .fl_by_va(fl_by_va), .fl_va(fl_va)
    );

    // reference model
    bit          m_v [NE];
    bit          m_g [NE];
    logic [8:0]  m_a [NE];
    logic [38:0] m_base [NE], m_low [NE];
    logic [55:0] m_pb [NE], m_pta [NE];
    logic [63:0] m_pte [NE];
    int          m_when [NE];
    int          fill_count = 0;

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;

    function automatic logic [38:0] mkva(int t2, int t1, int t0, int off);
        logic [63:0] v;
        v = (64'(t2) << 30) | (64'(t1) << 21) | (64'(t0) << 12) | 64'(off & 12'hfff);
        return v[38:0];
    endfunction

    task automatic idle();
        fill_en = 0; fl_en = 0; fl_by_asid = 0; fl_by_va = 0;
    endtask

    task automatic put(input logic [8:0] a, input bit g, input int lvl, input logic [38:0] va,
                       input logic [55:0] pa, input logic [63:0] pte, input logic [55:0] pta);
        fill_en = 1; fill_asid = a; fill_global = g; fill_level = 2'(lvl);
        fill_va = va; fill_pa = pa; fill_pte = pte; fill_pte_addr = pta;
    endtask

    task automatic drop(input bit by_a, input logic [8:0] a, input bit by_v, input logic [38:0] va);
        fl_en = 1; fl_by_asid = by_a; fl_asid = a; fl_by_va = by_v; fl_va = va;
    endtask

    task automatic look(input logic [8:0] a, input logic [38:0] va);
        lk_asid = a; lk_va = va;
    endtask

    // compare this cycle's lookup, then advance the model and the clock
    task automatic tick(input string tag);
        bit          eh;
        logic [55:0] ep, ea;
        logic [63:0] et;
        int          vic;
        logic [38:0] low;
        #1;
        eh = 0; ep = '0; ea = '0; et = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (m_v[i] && (m_g[i] || m_a[i] == lk_asid) && m_base[i] == (lk_va & ~m_low[i])) begin
                eh = 1;
                ep = m_pb[i] | {17'b0, lk_va & m_low[i]};
                ea = m_pta[i];
                et = m_pte[i];
            end
        end
        n_run++;
        if (lk_hit !== eh || lk_pa !== ep || lk_pte !== et || lk_pte_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: actual hit=%0b pa=%h pte=%h pta=%h expected hit=%0b pa=%h pte=%h pta=%h",
                     tag, lk_hit, lk_pa, lk_pte, lk_pte_addr, eh, ep, et, ea);
        end
        // victim from pre-invalidation state (R6, R7)
        vic = -1;
        for (int i = 0; i < NE; i++) if (vic < 0 && !m_v[i]) vic = i;
        if (vic < 0) begin
            vic = 0;
            for (int i = 1; i < NE; i++) if (m_when[i] < m_when[vic]) vic = i;
        end
        if (fl_en) begin
            for (int i = 0; i < NE; i++) begin
                bit tm, am;
                tm = (m_a[i] == fl_asid) && !m_g[i];
                am = (m_base[i] == (fl_va & ~m_low[i]));
                if ((!fl_by_asid && !fl_by_va) || (fl_by_va && !fl_by_asid && am) ||
                    (fl_by_asid && !fl_by_va && tm) || (fl_by_asid && fl_by_va && tm && am))
                    m_v[i] = 0;
            end
        end
        if (fill_en) begin
            low = (39'd1 << (12 + 9 * int'(fill_level))) - 39'd1;
            m_v[vic] = 1; m_g[vic] = fill_global; m_a[vic] = fill_asid;
            m_low[vic] = low; m_base[vic] = fill_va & ~low;
            m_pb[vic] = fill_pa & ~{17'b0, low};
            m_pte[vic] = fill_pte; m_pta[vic] = fill_pte_addr;
            m_when[vic] = fill_count++;
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=still running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        look(0, mkva(1, 2, 3, 0)); tick("R1 empty after reset");
        look(5, mkva(0, 0, 0, 0)); tick("R1 empty after reset");
        // R2 R3 R4 level 0
        put(5, 0, 0, mkva(1, 2, 3, 12'h456), 56'h12_3456_789A_BFFF, 64'h11, 56'h1000);
        look(5, mkva(1, 2, 3, 0)); tick("R12 fill not yet visible");
        look(5, mkva(1, 2, 3, 12'h7ff)); tick("R2 R3 4K hit");
        look(6, mkva(1, 2, 3, 12'h7ff)); tick("R4 tag mismatch");
        look(5, mkva(1, 2, 4, 0)); tick("R4 page mismatch");
        // global 2M
        put(1, 1, 1, mkva(2, 5, 7, 12'h10), 56'h40_0000_1234, 64'h22, 56'h2000); tick("R2 fill 2M");
        look(9, mkva(2, 5, 9'h1ff, 12'hfff)); tick("R2 R3 global 2M");
        look(0, mkva(2, 6, 0, 0)); tick("R4 2M outside");
        // 1G
        put(3, 0, 2, mkva(3, 9'h44, 9'h55, 12'h66), 56'hF_FFFF_FFFF_FFFF, 64'h33, 56'h3000); tick("R2 fill 1G");
        look(3, mkva(3, 1, 2, 3)); tick("R2 R3 1G");
        // R5 overlap: slot 3 is 1G, slot 4 is 4K inside it
        put(7, 0, 2, mkva(4, 0, 0, 0), 56'h80_0000_0000, 64'hA, 56'h4000); tick("R6 fill slot");
        put(7, 0, 0, mkva(4, 0, 1, 0), 56'h90_0000_0000, 64'hB, 56'h5000); tick("R6 fill slot");
        look(7, mkva(4, 0, 1, 5)); tick("R5 lowest slot wins");
        for (int k = 0; k < 3; k++) begin
            put(2, 0, 0, mkva(5, k, 0, 0), 56'(k) << 20, 64'(k + 64'h100), 56'h6000); tick("R6 fill to full");
        end
        // R7 replacement of oldest
        put(2, 0, 0, mkva(6, 0, 0, 0), 56'hAA000, 64'hCC, 56'h7000);
        look(5, mkva(1, 2, 3, 0)); tick("R7 before replace");
        look(5, mkva(1, 2, 3, 0)); tick("R7 oldest evicted");
        look(2, mkva(6, 0, 0, 9)); tick("R7 new entry hits");
        // R12 / R8
        drop(0, 0, 0, 0); look(2, mkva(6, 0, 0, 9)); tick("R12 lookup sees old state");
        look(2, mkva(6, 0, 0, 9)); tick("R8 all flushed");
        look(9, mkva(2, 5, 0, 0)); tick("R8 global flushed");
        // refill for filtered invalidations
        put(0, 1, 0, mkva(7, 0, 0, 0), 56'h1_000, 64'h51, 56'h100); tick("R6 refill");
        put(4, 0, 0, mkva(7, 0, 1, 0), 56'h2_000, 64'h52, 56'h200); tick("R6 refill");
        put(4, 0, 1, mkva(7, 1, 0, 0), 56'h400_000, 64'h53, 56'h300); tick("R6 refill");
        put(5, 0, 0, mkva(7, 0, 2, 0), 56'h3_000, 64'h54, 56'h400); tick("R6 refill");
        drop(1, 4, 0, 0); tick("R10 tag flush");
        look(4, mkva(7, 0, 0, 1)); tick("R10 global kept");
        look(4, mkva(7, 0, 1, 1)); tick("R10 tagged 4K gone");
        look(4, mkva(7, 1, 3, 1)); tick("R10 tagged 2M gone");
        look(5, mkva(7, 0, 2, 1)); tick("R10 other tag kept");
        drop(0, 0, 1, mkva(7, 0, 0, 12'h123)); tick("R9 address flush");
        look(4, mkva(7, 0, 0, 1)); tick("R9 global removed");
        put(6, 0, 0, mkva(8, 0, 0, 0), 56'h8_000, 64'h61, 56'h500); tick("R6 hole fill");
        put(5, 0, 0, mkva(8, 0, 0, 0), 56'h9_000, 64'h62, 56'h600); tick("R6 hole fill");
        drop(1, 5, 1, mkva(8, 0, 0, 12'h44)); tick("R11 both filters");
        look(5, mkva(8, 0, 0, 2)); tick("R11 matching entry gone");
        look(6, mkva(8, 0, 0, 2)); tick("R11 other tag kept");
        look(5, mkva(7, 0, 2, 2)); tick("R11 other page kept");
        for (int k = 0; k < 8; k++) begin
            put(3, 0, 0, mkva(9, k, 0, 0), 56'(k + 1) << 12, 64'(k + 64'h700), 56'h800);
            look(6, mkva(8, 0, 0, 2)); tick("R6 R7 fill pattern");
        end
        look(5, mkva(7, 0, 2, 2)); tick("R7 oldest after holes");
        // R13
        put(1, 0, 0, mkva(10, 0, 0, 0), 56'hB_000, 64'h99, 56'h900); drop(0, 0, 0, 0); tick("R13 fill with flush");
        look(1, mkva(10, 0, 0, 3)); tick("R13 new entry survives");
        look(3, mkva(9, 7, 0, 3)); tick("R13 others flushed");
        // mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom_range(0, 15));
            if (r < 6) put(9'($urandom_range(0, 3)), r == 0, int'($urandom_range(0, 2)),
                          mkva(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                               int'($urandom_range(0, 3)), int'($urandom)),
                          56'($urandom) << 12 | 56'($urandom), 64'($urandom), 56'($urandom));
            if (r == 15) drop(1'($urandom_range(0, 1)), 9'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                             mkva(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                                  int'($urandom_range(0, 3)), 0));
            look(9'($urandom_range(0, 3)), mkva(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                                                 int'($urandom_range(0, 3)), int'($urandom)));
            tick("R3 R5 R7 R9 R11 mixed traffic");
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule